// File: doc/BRIEF.md
# Descriptor Ring Address Walker

This block walks one descriptor ring, either transmit or receive, and enforces the ownership handshake between the device and the host. A start pulse captures the ring configuration: base address, entry count, a layout style code and an upper address byte. The walker then fetches descriptors one after another. For each descriptor it asks the bus side to read the status word and looks at the returned ownership bit. When the device owns the descriptor, the walker raises `devOwns` and holds it until the consumer signals that the entry is finished and handed back. It then moves to the next entry. After the last entry it wraps to index 0. When the host still owns a descriptor, the walker stalls on it and fetches it again only when it sees a poll strobe. It never skips ahead.

Two layout styles are supported. The compact style uses 8-byte entries and an 8-byte aligned base. In this style the top address byte comes from a separate configuration byte and the lower 24 bits wrap on their own. The wide styles use 16-byte entries, a 16-byte aligned base and a full 32-bit address. Any entry count from 1 to 65535 is accepted in every style. A start with a bad configuration raises an error flag and does not begin a walk.

Top module: `ringWalker`

## Requirements
- R1: After reset the walker is idle: `fetchReq`=0, `devOwns`=0, `cfgErr`=0, `curIdx`=0 and `curAddr`=0.
- R2: A start is rejected in any of these cases: `cfgStyle`=1, or `cfgStyle`=0 with `cfgBase[2:0]`≠0, or `cfgStyle`∈{2,3} with `cfgBase[3:0]`≠0, or `cfgLen`=0. A rejected start sets `cfgErr`=1, leaves the walker idle and keeps the captured ring state. A valid start clears `cfgErr`.
- R3: A valid start captures the configuration on that clock edge. From the next cycle `curIdx`=0, `curAddr` is the ring base and `fetchReq`=1. Later changes to the configuration inputs have no effect until the next start.
- R4: With `cfgStyle`=0, `curAddr[31:24]` is the captured upper byte and `curAddr[23:0]` equals (base[23:0] + 8·index) mod 2^24.
- R5: With `cfgStyle` 2 or 3, `curAddr` equals (base + 16·index) mod 2^32.
- R6: `fetchReq` stays high until a cycle with `fetchAck`=1. `fetchAddr` always equals `curAddr` and is 4-byte aligned while `fetchReq` is high.
- R7: An acknowledged fetch with `fetchOwn`=1 gives `devOwns`=1 in the next cycle. `devOwns` stays high until `doneStrobe`, and `pollStrobe` has no effect in that state.
- R8: An acknowledged fetch with `fetchOwn`=0 stalls the walker at the same index with `fetchReq`=0 and `devOwns`=0. `doneStrobe` has no effect while stalled. `pollStrobe` makes the walker fetch the same descriptor again in the next cycle.
- R9: `doneStrobe` while `devOwns`=1 moves the walker to index+1 and fetches that entry in the next cycle. After index `cfgLen`−1 it wraps to index 0 and the base address.
- R10: A start has priority in every state. A start during a walk restarts the walker under the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgBase | input | 32 | Ring base address |
| cfgLen | input | 16 | Ring entry count (1..65535) |
| cfgStyle | input | 2 | Layout style: 0 compact, 2/3 wide, 1 invalid |
| cfgUpper | input | 8 | Upper address byte for the compact style |
| start | input | 1 | Capture configuration and begin at index 0 |
| pollStrobe | input | 1 | Re-fetch a stalled descriptor |
| doneStrobe | input | 1 | Consumer has handed back the current entry |
| fetchReq | output | 1 | Status word fetch request |
| fetchAddr | output | 32 | Address of the descriptor being fetched |
| fetchAck | input | 1 | Fetch completed; `fetchOwn` is valid |
| fetchOwn | input | 1 | Ownership bit read back: 1 means the device owns the descriptor |
| curAddr | output | 32 | Current descriptor address |
| curIdx | output | 16 | Current descriptor index |
| devOwns | output | 1 | Device holds the current descriptor |
| cfgErr | output | 1 | Last start was rejected |

## Verification
The assertions assume that the configuration inputs matter only on the edge where `start` is high. They also assume that `fetchOwn` is read only together with `fetchAck`, and that `fetchAck` means something only while a request is pending. The bench keeps to these assumptions in two ways. It changes the configuration freely between starts, including right after a start, which exercises the capture rule. It also drives `fetchAck`, `doneStrobe` and `pollStrobe` at random in every state, so these strobes are seen when they must be ignored as well as when they act. Bases are mostly drawn aligned for the chosen style, with some misaligned ones, an invalid style code and a zero length mixed in.

// File: rtl/ringWalkPkg.sv
package ringWalkPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_OWNED = 2'd2,
    ST_WAIT  = 2'd3
  } walkState_t;

  typedef struct packed {
    logic load;
    logic advance;
  } walkStrobe_t;

  localparam logic [1:0] STYLE_COMPACT = 2'd0;
  localparam logic [1:0] STYLE_INVALID = 2'd1;
endpackage

// File: rtl/ringWalkDatapath.sv
module ringWalkDatapath
  import ringWalkPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [1:0]        cfgStyle,
  input  logic [EXT_W-1:0]  cfgUpper,
  input  walkStrobe_t       strobe,
  output logic              cfgOk,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  curIdx
);
  localparam int LOW_W = ADDR_W - EXT_W;
  localparam logic [ADDR_W-1:0] NARROW_STEP = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] WIDE_STEP   = ADDR_W'(16);

  logic [ADDR_W-1:0] baseQ, offQ, stepSel;
  logic [LEN_W-1:0]  lenQ, idxQ;
  logic [EXT_W-1:0]  upperQ;
  logic              wideQ, lastEntry;
  logic              styleOk, alignOk, lenOk;

  always_comb begin
    styleOk = (cfgStyle != STYLE_INVALID);
    alignOk = (cfgStyle == STYLE_COMPACT) ? (cfgBase[2:0] == 3'b000)
                                          : (cfgBase[3:0] == 4'b0000);
    lenOk   = (cfgLen != '0);
    cfgOk   = styleOk && alignOk && lenOk;
  end

  assign lastEntry = (idxQ == lenQ - LEN_W'(1));
  assign stepSel   = wideQ ? WIDE_STEP : NARROW_STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      lenQ   <= '0;
      upperQ <= '0;
      wideQ  <= 1'b0;
      idxQ   <= '0;
      offQ   <= '0;
    end else if (strobe.load) begin
      baseQ  <= cfgBase;
      lenQ   <= cfgLen;
      upperQ <= cfgUpper;
      wideQ  <= (cfgStyle != STYLE_COMPACT);
      idxQ   <= '0;
      offQ   <= '0;
    end else if (strobe.advance) begin
      if (lastEntry) begin
        idxQ <= '0;
        offQ <= '0;
      end else begin
        idxQ <= idxQ + LEN_W'(1);
        offQ <= offQ + stepSel;
      end
    end
  end

  logic [LOW_W-1:0] lowSum;
  assign lowSum  = baseQ[LOW_W-1:0] + offQ[LOW_W-1:0];
  assign curAddr = wideQ ? (baseQ + offQ) : {upperQ, lowSum};
  assign curIdx  = idxQ;

  // R9
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.load && (idxQ == lenQ - LEN_W'(1)) |=> idxQ == '0);
  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.load && (idxQ != lenQ - LEN_W'(1)) |=> idxQ == $past(idxQ) + LEN_W'(1));
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.advance |=> $stable(idxQ) && $stable(baseQ) && $stable(lenQ));
  // R3
  load_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> idxQ == '0 && curAddr[3:0] == $past(cfgBase[3:0]));
endmodule

// File: rtl/ringWalkControl.sv
module ringWalkControl
  import ringWalkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cfgOk,
  input  logic        fetchAck,
  input  logic        fetchOwn,
  input  logic        pollStrobe,
  input  logic        doneStrobe,
  output walkStrobe_t strobe,
  output logic        fetchReq,
  output logic        devOwns,
  output logic        cfgErr
);
  walkState_t stateQ, stateD;
  logic       errD;

  always_comb begin
    stateD         = stateQ;
    errD           = cfgErr;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    if (start) begin
      if (cfgOk) begin
        strobe.load = 1'b1;
        stateD      = ST_FETCH;
        errD        = 1'b0;
      end else begin
        stateD = ST_IDLE;
        errD   = 1'b1;
      end
    end else begin
      unique case (stateQ)
        ST_IDLE:  stateD = ST_IDLE;
        ST_FETCH: if (fetchAck) stateD = fetchOwn ? ST_OWNED : ST_WAIT;
        ST_OWNED: if (doneStrobe) begin
                    strobe.advance = 1'b1;
                    stateD         = ST_FETCH;
                  end
        ST_WAIT:  if (pollStrobe) stateD = ST_FETCH;
        default:  stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cfgErr <= 1'b0;
    end else begin
      stateQ <= stateD;
      cfgErr <= errD;
    end
  end

  assign fetchReq = (stateQ == ST_FETCH);
  assign devOwns  = (stateQ == ST_OWNED);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck && !start |=> fetchReq);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_WAIT && !pollStrobe && !start |=> stateQ == ST_WAIT);
  // R7
  own_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    devOwns && !doneStrobe && !start |=> devOwns);
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !fetchReq && !devOwns);
  // R7
  own_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchAck && fetchOwn && !start |=> devOwns);
endmodule

// File: rtl/ringWalker.sv
module ringWalker
  import ringWalkPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [1:0]        cfgStyle,
  input  logic [EXT_W-1:0]  cfgUpper,
  input  logic              start,
  input  logic              pollStrobe,
  input  logic              doneStrobe,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic              fetchOwn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  curIdx,
  output logic              devOwns,
  output logic              cfgErr
);
  walkStrobe_t strobe;
  logic        cfgOk;

  ringWalkControl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .cfgOk(cfgOk),
    .fetchAck(fetchAck), .fetchOwn(fetchOwn),
    .pollStrobe(pollStrobe), .doneStrobe(doneStrobe),
    .strobe(strobe), .fetchReq(fetchReq), .devOwns(devOwns), .cfgErr(cfgErr)
  );

  ringWalkDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .EXT_W(EXT_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgLen(cfgLen),
    .cfgStyle(cfgStyle), .cfgUpper(cfgUpper), .strobe(strobe),
    .cfgOk(cfgOk), .curAddr(curAddr), .curIdx(curIdx)
  );

  assign fetchAddr = curAddr;

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> fetchAddr[1:0] == 2'b00);
  // R8
  stall_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq && !devOwns && !start |=> $stable(curIdx));
endmodule

// File: tb/tb_ringWalker.sv
module tb_ringWalker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [15:0] cfgLen = '0;
  logic [1:0]  cfgStyle = '0;
  logic [7:0]  cfgUpper = '0;
  logic        start = 0, pollStrobe = 0, doneStrobe = 0, fetchAck = 0, fetchOwn = 0;
  logic        fetchReq, devOwns, cfgErr;
  logic [31:0] fetchAddr, curAddr;
  logic [15:0] curIdx;

  int vecCount = 0;
  int failCount = 0;

  ringWalker dut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgLen(cfgLen),
    .cfgStyle(cfgStyle), .cfgUpper(cfgUpper), .start(start),
    .pollStrobe(pollStrobe), .doneStrobe(doneStrobe),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchOwn(fetchOwn), .curAddr(curAddr), .curIdx(curIdx),
    .devOwns(devOwns), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: 0 idle, 1 fetching, 2 device owns, 3 stalled
  int          mState = 0;
  int          mIdx = 0;
  int          mLen = 0;
  bit          mErr = 0;
  bit          mWide = 0;
  logic [31:0] mBase = '0;
  logic [7:0]  mUpper = '0;

  function automatic logic [31:0] modelAddr();
    logic [31:0] off;
    logic [23:0] low;
    if (mWide) return mBase + 32'(mIdx) * 32'd16;
    off = 32'(mIdx) * 32'd8;
    low = mBase[23:0] + off[23:0];
    return {mUpper, low};
  endfunction

  function automatic bit configGood(logic [31:0] b, logic [15:0] l, logic [1:0] s);
    if (s == 2'd1 || l == 16'd0) return 0;
    if (s == 2'd0) return b % 8 == 0;
    return b % 16 == 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mLen = 0; mErr = 0; mWide = 0; mBase = '0; mUpper = '0;
    end else if (start) begin
      if (configGood(cfgBase, cfgLen, cfgStyle)) begin
        mBase = cfgBase; mLen = int'(cfgLen); mUpper = cfgUpper;
        mWide = (cfgStyle != 2'd0); mIdx = 0; mState = 1; mErr = 0;
      end else begin
        mState = 0; mErr = 1;
      end
    end else begin
      case (mState)
        1: if (fetchAck) mState = fetchOwn ? 2 : 3;
        2: if (doneStrobe) begin
             mIdx = (mIdx == mLen - 1) ? 0 : mIdx + 1;
             mState = 1;
           end
        3: if (pollStrobe) mState = 1;
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R6 fetchReq", 32'(fetchReq), 32'(mState == 1));
    check("R7 devOwns", 32'(devOwns), 32'(mState == 2));
    check("R2 cfgErr", 32'(cfgErr), 32'(mErr));
    check("R9 curIdx", 32'(curIdx), 32'(mIdx));
    check(mWide ? "R5 curAddr" : "R4 curAddr", curAddr, modelAddr());
    check("R6 fetchAddr", fetchAddr, modelAddr());
  endtask

  task automatic tick(input logic st, input logic ak, input logic ow,
                      input logic dn, input logic pl);
    start = st; fetchAck = ak; fetchOwn = ow; doneStrobe = dn; pollStrobe = pl;
    @(negedge clk);
    compareAll();
  endtask

  task automatic setCfg(input logic [31:0] b, input logic [15:0] l,
                        input logic [1:0] s, input logic [7:0] u);
    cfgBase = b; cfgLen = l; cfgStyle = s; cfgUpper = u;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(0,0,0,0,0); tick(0,0,0,0,0);
    // R1 reset state
    check("R1 fetchReq", 32'(fetchReq), 0);
    check("R1 devOwns", 32'(devOwns), 0);
    check("R1 cfgErr", 32'(cfgErr), 0);
    check("R1 curIdx", 32'(curIdx), 0);
    check("R1 curAddr", curAddr, 0);
    rstN = 1'b1;
    tick(0,0,0,0,0);

    // R2 rejected configurations
    setCfg(32'h0000_1004, 16'd4, 2'd0, 8'h11); tick(1,0,0,0,0); tick(0,0,0,0,0);
    check("R2 misaligned compact", 32'(cfgErr), 1);
    setCfg(32'h0000_1008, 16'd4, 2'd2, 8'h11); tick(1,0,0,0,0);
    check("R2 misaligned wide", 32'(cfgErr), 1);
    setCfg(32'h0000_1000, 16'd4, 2'd1, 8'h11); tick(1,0,0,0,0);
    check("R2 bad style", 32'(cfgErr), 1);
    setCfg(32'h0000_1000, 16'd0, 2'd3, 8'h11); tick(1,0,0,0,0);
    check("R2 zero length", 32'(fetchReq), 0);

    // R3 / R4 compact ring crossing the 24-bit boundary
    setCfg(32'h00FF_FFF8, 16'd3, 2'd0, 8'hAB); tick(1,0,0,0,0);
    check("R3 start index", 32'(curIdx), 0);
    check("R3 start addr", curAddr, 32'hABFF_FFF8);
    check("R2 error cleared", 32'(cfgErr), 0);
    setCfg(32'hDEAD_BEE0, 16'd9, 2'd3, 8'h55);   // R3 ignored until next start
    tick(0,1,1,0,0); tick(0,0,0,0,1);            // R7 poll ignored while owned
    check("R7 owned", 32'(devOwns), 1);
    tick(0,0,0,1,0);
    check("R4 upper byte kept, low wraps", curAddr, 32'hAB00_0000);
    tick(0,1,0,0,0);                             // stall
    tick(0,0,0,1,0);                             // R8 done ignored
    check("R8 stalled index", 32'(curIdx), 1);
    check("R8 no request", 32'(fetchReq), 0);
    tick(0,0,0,0,1);
    check("R8 refetch", fetchAddr, 32'hAB00_0000);
    tick(0,1,1,0,0); tick(0,0,0,1,0);
    tick(0,1,1,0,0); tick(0,0,0,1,0);
    check("R9 wrap index", 32'(curIdx), 0);
    check("R9 wrap addr", curAddr, 32'hABFF_FFF8);

    // R5 wide ring, then R10 restart mid-walk
    setCfg(32'h1234_0010, 16'd5, 2'd3, 8'h00); tick(1,0,0,0,0);
    tick(0,1,1,0,0); tick(0,0,0,1,0);
    check("R5 wide addr", curAddr, 32'h1234_0020);
    tick(0,1,1,0,0);
    setCfg(32'hFFFF_FFF0, 16'd2, 2'd2, 8'h00); tick(1,0,0,1,0);
    check("R10 restart idx", 32'(curIdx), 0);
    check("R10 restart addr", curAddr, 32'hFFFF_FFF0);
    tick(0,1,1,0,0); tick(0,0,0,1,0);
    check("R5 wide wrap 2^32", curAddr, 32'h0000_0000);

    // Random traffic
    for (int i = 0; i < 8000; i++) begin
      logic st;
      st = ($urandom % 100) < 2;
      if (st) begin
        logic [1:0] s;
        logic [31:0] b;
        s = 2'($urandom % 4);
        b = $urandom;
        if (($urandom % 8) != 0) b = (s == 2'd0) ? {b[31:3], 3'b000} : {b[31:4], 4'b0000};
        setCfg(b, 16'(($urandom % 10 == 0) ? 0 : 1 + $urandom % 6), s, 8'($urandom));
      end else if (($urandom % 4) == 0) begin
        setCfg($urandom, 16'($urandom), 2'($urandom), 8'($urandom)); // R3 noise
      end
      tick(st, ($urandom % 2) == 0, ($urandom % 10) < 7,
           ($urandom % 5) < 2, ($urandom % 10) < 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule